// File: doc/BRIEF.md
# Enclosure LED Serial Transmitter

This block drives the indicator LEDs of a drive enclosure over a three-wire serial link made of a clock line, a load line and a data line. It holds a packed pattern with three indicator bits for each drive port (activity, locate and fault). Each port's bits sit at a chain position that a configuration table gives. A message arrives on a valid/ready handshake together with a port number. The block rewrites that port's three bits, leaves every other bit as it was, and then sends the whole pattern to the LED controller.

A transfer starts with one system clock with all lines low (ST_ARM). A framing clock cycle follows, with load held high through its high phase (ST_LOAD_HI) and its low phase (ST_LOAD_LO). Then come three data bits per configured port, least significant first. Each data bit is placed on the line for one system clock (ST_SETUP) before its clock high phase (ST_DATA_HI) and low phase (ST_DATA_LO). Every clock half-period is counted out from the system clock by a divider. A message arriving in ST_BOOT (the reset state, all lines high) or ST_IDLE (all lines low) is taken. A valid message with messaging enabled moves ST_BOOT/ST_IDLE to ST_ARM. ST_ARM always moves to ST_LOAD_HI. ST_LOAD_HI moves to ST_LOAD_LO on the half-period tick. ST_LOAD_LO moves to ST_SETUP on the tick, or to ST_IDLE if no data bits are due. ST_SETUP always moves to ST_DATA_HI. ST_DATA_HI moves to ST_DATA_LO on the tick. ST_DATA_LO moves back to ST_SETUP on the tick, or to ST_IDLE after the last bit.

A message whose slot field is out of range is acknowledged, flagged with a one-cycle error pulse and otherwise dropped. With messaging disabled, messages are acknowledged and dropped silently.

Top module: `sgpio_led_tx`

## Requirements
- R1: While reset is held and after it is released, until the first transfer, sgp_clk, sgp_load and sgp_data are 1, msg_ready is 1 and msg_err is 0.
- R2: The indicators are decoded from msg_word as follows: activity = bit 20 OR bit 21, locate = bit 19, fault = bit 22. All other bits of msg_word, apart from the slot field, have no effect on the pattern.
- R3: An accepted, enabled message for port p with chain position m = chain_map[3p+2:3p] sets pattern bit 3m+2 to activity, 3m+1 to locate and 3m+0 to fault. Every other pattern bit keeps its value.
- R4: A transfer has exactly one clock rise with sgp_load high, and it comes before any data. It is followed by 3*min(port_count, MAX_PORTS) clock rises with sgp_load low.
- R5: Data bit i of the burst is pattern bit i (LSB first). It is on sgp_data at least one system clock before its clock rise and stays stable while sgp_clk is high.
- R6: Within a transfer, each sgp_clk high phase lasts HALF_CYC system clocks. Each low gap between consecutive rises lasts HALF_CYC+1 system clocks (the low half-period plus the data setup cycle).
- R7: A message whose slot field msg_word[11:8] is >= MAX_SLOTS is acknowledged. msg_err is 1 in the cycle after acceptance, msg_ready stays 1, no transfer starts and the pattern is unchanged. Slot MAX_SLOTS-1 is accepted normally with msg_err 0.
- R8: With led_msg_en = 0, a message is acknowledged with msg_err 0. msg_ready stays 1, no transfer starts and the pattern is unchanged.
- R9: msg_ready is 0 from the cycle after an enabled message is accepted until the last data low phase ends. After a transfer, all three serial lines are 0 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Message offered |
| msg_ready | output | 1 | Block can take a message |
| msg_port | input | PORT_W (3) | Drive port the message is for |
| msg_word | input | 32 | Message: slot in [11:8], indicators in [22:19] |
| led_msg_en | input | 1 | LED messaging enabled |
| port_count | input | CNT_W (4) | Number of ports on the serial chain |
| chain_map | input | MAX_PORTS*PORT_W (24) | Chain position for each port, port p at [PORT_W*p +: PORT_W] |
| sgp_clk | output | 1 | Serial clock |
| sgp_load | output | 1 | Serial frame marker |
| sgp_data | output | 1 | Serial data |
| msg_err | output | 1 | One-cycle pulse for a rejected message |

## Verification
Every port is sent every combination of the three indicators through a chain map that is a non-identity permutation, so a wrong field position or a wrong map lookup shows up as a misplaced bit in the received burst. Activity is raised alternately through bit 20 and bit 21, and unrelated message bits carry fixed non-zero noise. This separates the OR decode from decoding only one of the two bits, and shows that stray bits are ignored. Slots run from 7 to 14 and are followed by a slot of 15, which tells the last legal slot apart from the first illegal one. The messages sent after a rejected or disabled message show whether the dropped message left the pattern untouched. A second sweep with a three-port chain shows whether the burst length follows the configured count and not the maximum.

// File: rtl/sgpio_tx_pkg.sv
`timescale 1ns/1ps
package sgpio_tx_pkg;

    localparam int unsigned IND_PER_PORT = 3;
    localparam int unsigned SH_FAULT     = 0;
    localparam int unsigned SH_LOCATE    = 1;
    localparam int unsigned SH_ACTIVITY  = 2;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_ARM,
        ST_LOAD_HI,
        ST_LOAD_LO,
        ST_SETUP,
        ST_DATA_HI,
        ST_DATA_LO
    } link_state_e;

    typedef struct packed {
        logic act;
        logic loc;
        logic flt;
    } ind_t;

endpackage

// File: rtl/sgpio_msg_decode.sv
`timescale 1ns/1ps
module sgpio_msg_decode
    import sgpio_tx_pkg::*;
#(
    parameter int unsigned MAX_SLOTS = 15
) (
    input  logic [3:0] ind_field,   // message bits [22:19]
    input  logic [3:0] slot_field,  // message bits [11:8]
    output ind_t       ind,
    output logic       slot_ok
);

    always_comb begin
        ind.loc = ind_field[0];
        ind.act = ind_field[1] | ind_field[2];
        ind.flt = ind_field[3];
        slot_ok = (32'(slot_field) < MAX_SLOTS);
    end

endmodule

// File: rtl/sgpio_pattern_merge.sv
`timescale 1ns/1ps
module sgpio_pattern_merge
    import sgpio_tx_pkg::*;
#(
    parameter int unsigned MAX_PORTS = 8,
    parameter int unsigned POS_W     = 3,
    localparam int unsigned PAT_W    = MAX_PORTS * IND_PER_PORT
) (
    input  logic [PAT_W-1:0] pattern_in,
    input  logic [POS_W-1:0] chain_pos,
    input  ind_t             ind,
    output logic [PAT_W-1:0] pattern_out
);

    for (genvar g = 0; g < MAX_PORTS; g++) begin : g_group
        logic hit;
        assign hit = (chain_pos == POS_W'(g));
        assign pattern_out[IND_PER_PORT*g + SH_ACTIVITY] =
            hit ? ind.act : pattern_in[IND_PER_PORT*g + SH_ACTIVITY];
        assign pattern_out[IND_PER_PORT*g + SH_LOCATE] =
            hit ? ind.loc : pattern_in[IND_PER_PORT*g + SH_LOCATE];
        assign pattern_out[IND_PER_PORT*g + SH_FAULT] =
            hit ? ind.flt : pattern_in[IND_PER_PORT*g + SH_FAULT];
    end

endmodule

// File: rtl/sgpio_half_timer.sv
`timescale 1ns/1ps
module sgpio_half_timer #(
    parameter int unsigned HALF_CYC = 2500,
    localparam int unsigned CNT_W   = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == CNT_W'(HALF_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run && !tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end else begin
            cnt_q <= '0;
        end
    end

endmodule

// File: rtl/sgpio_led_tx.sv
`timescale 1ns/1ps
module sgpio_led_tx
    import sgpio_tx_pkg::*;
#(
    parameter int unsigned MAX_PORTS = 8,
    parameter int unsigned HALF_CYC  = 2500,
    parameter int unsigned MAX_SLOTS = 15,
    localparam int unsigned PORT_W   = (MAX_PORTS > 1) ? $clog2(MAX_PORTS) : 1,
    localparam int unsigned CNT_W    = $clog2(MAX_PORTS + 1),
    localparam int unsigned PAT_W    = MAX_PORTS * IND_PER_PORT,
    localparam int unsigned BIT_W    = $clog2(PAT_W + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        msg_valid,
    output logic                        msg_ready,
    input  logic [PORT_W-1:0]           msg_port,
    input  logic [31:0]                 msg_word,
    input  logic                        led_msg_en,
    input  logic [CNT_W-1:0]            port_count,
    input  logic [MAX_PORTS*PORT_W-1:0] chain_map,
    output logic                        sgp_clk,
    output logic                        sgp_load,
    output logic                        sgp_data,
    output logic                        msg_err
);

    link_state_e      state_q, state_d;
    logic [PAT_W-1:0] pattern_q, merged;
    logic [PAT_W-1:0] shift_q;
    logic [BIT_W-1:0] bits_left_q, bits_total;
    logic [CNT_W-1:0] eff_count;
    logic [PORT_W-1:0] chain_pos;
    ind_t             ind;
    logic             slot_ok, accept, start, tick, timed, err_q;

    logic unused_msg_bits;
    assign unused_msg_bits = ^{msg_word[31:23], msg_word[18:12], msg_word[7:0]};

    sgpio_msg_decode #(.MAX_SLOTS(MAX_SLOTS)) u_dec (
        .ind_field (msg_word[22:19]),
        .slot_field(msg_word[11:8]),
        .ind       (ind),
        .slot_ok   (slot_ok)
    );

    always_comb begin
        chain_pos = '0;
        for (int i = 0; i < MAX_PORTS; i++) begin
            if (msg_port == PORT_W'(i)) chain_pos = chain_map[PORT_W*i +: PORT_W];
        end
    end

    sgpio_pattern_merge #(.MAX_PORTS(MAX_PORTS), .POS_W(PORT_W)) u_merge (
        .pattern_in (pattern_q),
        .chain_pos  (chain_pos),
        .ind        (ind),
        .pattern_out(merged)
    );

    assign timed = (state_q == ST_LOAD_HI) || (state_q == ST_LOAD_LO) ||
                   (state_q == ST_DATA_HI) || (state_q == ST_DATA_LO);

    sgpio_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (timed),
        .tick (tick)
    );

    assign msg_ready  = (state_q == ST_BOOT) || (state_q == ST_IDLE);
    assign accept     = msg_valid && msg_ready;
    assign start      = accept && slot_ok && led_msg_en;
    assign eff_count  = (port_count > CNT_W'(MAX_PORTS)) ? CNT_W'(MAX_PORTS) : port_count;
    assign bits_total = BIT_W'(eff_count) * BIT_W'(IND_PER_PORT);
    assign msg_err    = err_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT, ST_IDLE: if (start) state_d = ST_ARM;
            ST_ARM:           state_d = ST_LOAD_HI;
            ST_LOAD_HI:       if (tick) state_d = ST_LOAD_LO;
            ST_LOAD_LO:       if (tick) state_d = (bits_left_q == '0) ? ST_IDLE : ST_SETUP;
            ST_SETUP:         state_d = ST_DATA_HI;
            ST_DATA_HI:       if (tick) state_d = ST_DATA_LO;
            ST_DATA_LO:       if (tick) state_d = (bits_left_q == BIT_W'(1)) ? ST_IDLE : ST_SETUP;
            default:          state_d = ST_IDLE;
        endcase
    end

    // pattern, burst shifter and error pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pattern_q   <= '0;
            shift_q     <= '0;
            bits_left_q <= '0;
            err_q       <= 1'b0;
        end else begin
            err_q <= accept && !slot_ok;
            if (start) begin
                pattern_q   <= merged;
                shift_q     <= merged;
                bits_left_q <= bits_total;
            end else if ((state_q == ST_DATA_LO) && tick) begin
                shift_q     <= shift_q >> 1;
                bits_left_q <= bits_left_q - BIT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        sgp_clk  = 1'b0;
        sgp_load = 1'b0;
        sgp_data = 1'b0;
        unique case (state_q)
            ST_BOOT: begin
                sgp_clk  = 1'b1;
                sgp_load = 1'b1;
                sgp_data = 1'b1;
            end
            ST_IDLE, ST_ARM: ;
            ST_LOAD_HI: begin
                sgp_clk  = 1'b1;
                sgp_load = 1'b1;
            end
            ST_LOAD_LO: sgp_load = 1'b1;
            ST_SETUP, ST_DATA_LO: sgp_data = shift_q[0];
            ST_DATA_HI: begin
                sgp_clk  = 1'b1;
                sgp_data = shift_q[0];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sgpio_led_tx_chk.sv
`timescale 1ns/1ps
module sgpio_led_tx_chk #(
    parameter int unsigned MAX_SLOTS = 15
) (
    input logic       clk,
    input logic       rst_n,
    input logic       msg_valid,
    input logic       msg_ready,
    input logic [3:0] slot_field,
    input logic       led_msg_en,
    input logic       sgp_clk,
    input logic       sgp_load,
    input logic       sgp_data,
    input logic       msg_err
);

    a_r7_err_follows_reject: assert property (@(posedge clk) disable iff (!rst_n)
        msg_err |-> $past(msg_valid && msg_ready && (32'(slot_field) >= MAX_SLOTS)));

    a_r7_reject_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
        msg_err |-> msg_ready);

    a_r8_disabled_stays_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready && !led_msg_en) |=> msg_ready);

    a_r9_no_ready_while_clocking: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sgp_clk) |-> !msg_ready);

    a_r4_load_drops_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sgp_load) |-> !sgp_clk);

    a_r5_data_held_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sgp_clk && $past(sgp_clk) && !sgp_load) |-> $stable(sgp_data));

endmodule

bind sgpio_led_tx sgpio_led_tx_chk #(.MAX_SLOTS(MAX_SLOTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .slot_field(msg_word[11:8]),
    .led_msg_en(led_msg_en),
    .sgp_clk   (sgp_clk),
    .sgp_load  (sgp_load),
    .sgp_data  (sgp_data),
    .msg_err   (msg_err)
);

// File: tb/sim_sgpio_led_tx.sv
`timescale 1ns/1ps
module sim_sgpio_led_tx;

    localparam int NP   = 8;
    localparam int HALF = 4;
    localparam int MS   = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic        msg_ready;
    logic [2:0]  msg_port = '0;
    logic [31:0] msg_word = '0;
    logic        led_msg_en = 1'b1;
    logic [3:0]  port_count = 4'd8;
    logic [23:0] chain_map;
    logic        sgp_clk, sgp_load, sgp_data, msg_err;

    int total = 0;
    int bad = 0;

    // monitor state
    logic        prev_clk = 1'b1, prev_data = 1'b1;
    int          mon_rises = 0, mon_nbits = 0, load_rises = 0;
    int          order_err = 0, setup_err = 0, width_err = 0;
    int          high_w = 0, low_w = 0;
    logic [31:0] mon_frame = '0;
    logic [23:0] exp_pat = '0;

    always #10 clk = ~clk;

    sgpio_led_tx #(.MAX_PORTS(NP), .HALF_CYC(HALF), .MAX_SLOTS(MS)) u0 (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_port(msg_port), .msg_word(msg_word), .led_msg_en(led_msg_en),
        .port_count(port_count), .chain_map(chain_map),
        .sgp_clk(sgp_clk), .sgp_load(sgp_load), .sgp_data(sgp_data), .msg_err(msg_err)
    );

    function automatic int map_of(input int p);
        return (3 * p + 1) % 8;
    endfunction

    always_comb begin
        for (int p = 0; p < NP; p++) chain_map[3*p +: 3] = 3'(map_of(p));
    end

    // receiver model at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (sgp_clk && !prev_clk) begin
                if (mon_rises > 0 && low_w != HALF + 1) width_err++;
                if (sgp_load) begin
                    load_rises++;
                    if (mon_nbits > 0) order_err++;
                end else begin
                    if (sgp_data != prev_data) setup_err++;
                    if (mon_nbits < 32) mon_frame[mon_nbits] = sgp_data;
                    mon_nbits++;
                end
                mon_rises++;
                high_w = 1;
            end else if (sgp_clk) begin
                high_w++;
            end
            if (!sgp_clk && prev_clk) begin
                if (mon_rises > 0 && high_w != HALF) width_err++;
                low_w = 1;
            end else if (!sgp_clk) begin
                low_w++;
            end
        end
        prev_clk  = sgp_clk;
        prev_data = sgp_data;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input int p, input int slot, input bit a20, input bit a21,
                        input bit l, input bit f, input bit exp_xfer, input bit exp_err);
        logic [31:0] w;
        logic [31:0] mask;
        int          n;
        w = 32'h3C00_50A5 | (32'(slot) << 8) | (32'(a20) << 20) | (32'(a21) << 21) |
            (32'(l) << 19) | (32'(f) << 22);
        @(posedge clk); #1;
        mon_rises = 0; mon_nbits = 0; load_rises = 0;
        order_err = 0; setup_err = 0; width_err = 0; mon_frame = '0;
        msg_port = 3'(p); msg_word = w; msg_valid = 1'b1;
        while (!msg_ready) begin @(posedge clk); #1; end
        @(posedge clk); #1;
        msg_valid = 1'b0;
        chk(exp_err ? "R7 err pulse" : "R7 no err", 32'(msg_err), 32'(exp_err));
        chk(exp_xfer ? "R9 ready low" : "R8 ready kept", 32'(msg_ready), 32'(!exp_xfer));
        if (exp_xfer) begin
            exp_pat[3*map_of(p) + 2] = a20 | a21;
            exp_pat[3*map_of(p) + 1] = l;
            exp_pat[3*map_of(p) + 0] = f;
            n = (port_count > 8) ? 8 : int'(port_count);
            while (!msg_ready) begin @(posedge clk); #1; end
            repeat (2) @(posedge clk); #1;
            mask = (32'd1 << (3 * n)) - 32'd1;
            chk("R2 R3 R5 burst", mon_frame & mask, {8'h0, exp_pat} & mask);
            chk("R4 bit count", 32'(mon_nbits), 32'(3 * n));
            chk("R4 one load clock first", 32'(load_rises + 2 * order_err), 32'd1);
            chk("R5 setup and hold", 32'(setup_err), 32'd0);
            chk("R6 half periods", 32'(width_err), 32'd0);
            chk("R9 idle lines low", {29'd0, sgp_clk, sgp_load, sgp_data}, 32'd0);
        end else begin
            repeat (4 * HALF) @(posedge clk); #1;
            chk(exp_err ? "R7 no transfer" : "R8 no transfer", 32'(mon_rises), 32'd0);
            chk(exp_err ? "R7 ready high" : "R8 ready high", 32'(msg_ready), 32'd1);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk); #1;
        chk("R1 reset lines", {29'd0, sgp_clk, sgp_load, sgp_data}, 32'd7);
        rst_n = 1'b1;
        repeat (2) @(posedge clk); #1;
        chk("R1 lines after release", {29'd0, sgp_clk, sgp_load, sgp_data}, 32'd7);
        chk("R1 ready", 32'(msg_ready), 32'd1);
        chk("R1 no err", 32'(msg_err), 32'd0);

        // full sweep: every port, every indicator combination, slots 7..14
        for (int p = 0; p < NP; p++) begin
            for (int c = 0; c < 8; c++) begin
                send(p, p + 7, c[2] & ~p[0], c[2] & p[0], c[1], c[0], 1'b1, 1'b0);
            end
        end
        // set everything on, then reject a message that would clear port 2
        for (int p = 0; p < NP; p++) send(p, 3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        send(2, 15, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        send(5, 14, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);  // R7 last legal slot; port 2 still on
        // disabled message for port 4 is dropped
        led_msg_en = 1'b0;
        send(4, 1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        led_msg_en = 1'b1;
        send(6, 1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);  // R8 port 4 unchanged in burst
        // short chain: three ports
        port_count = 4'd3;
        for (int p = 0; p < NP; p++) send(p, 0, p[0], 1'b0, p[1], p[2], 1'b1, 1'b0);
        // count above maximum is clamped
        port_count = 4'd12;
        send(3, 2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule